// File: doc/BRIEF.md
# Two-Level Page Table Walker

The block turns a 32-bit virtual address into a physical address by reading a two-level translation table from memory. A request supplies the virtual address together with the translation-table base. The walker fetches the first-level descriptor. Depending on that descriptor's type, it either finishes at once (a fault or a 1 MB section) or fetches a second-level descriptor from a coarse or fine table. The walk then ends with a page result or a fault.

Memory is reached through a simple word-read port. The walker raises a request, holds the address steady, and waits any number of cycles for the response. Each walk ends with a one-cycle completion pulse that carries one of two results:
- the physical address, a page-size code and the access attribute bits, which are passed through and not interpreted; or
- a fault flag and the table level that faulted.

Top module: `ptw_walker`

## Requirements
- R1: A request is taken only while `req_ready_o` is high, which is the case only in the idle state. A `req_valid_i` raised while a walk is in progress has no effect on that walk's reads or result.
- R2: The first read address is {ttb_i[31:14], va[31:20], 2'b00}.
- R3: A first-level descriptor with bits [1:0] = 00 ends the walk with `fault_o`=1 and `fault_lvl_o`=0, and no second read is made.
- R4: A first-level descriptor with bits [1:0] = 10 (section) ends the walk after one read. It gives `pa_o` = {desc[31:20], va[19:0]}, `size_o` = 0, and `attr_o` = {desc[11:10], desc[3], desc[2]}.
- R5: A first-level descriptor with bits [1:0] = 01 (coarse table) makes the second read at {desc[31:10], va[19:12], 2'b00}.
- R6: A first-level descriptor with bits [1:0] = 11 (fine table) makes the second read at {desc[31:12], va[19:10], 2'b00}.
- R7: A second-level descriptor with bits [1:0] = 01 (64 KB page) gives `pa_o` = {desc[31:16], va[15:0]} and `size_o` = 1.
- R8: A second-level descriptor with bits [1:0] = 11 or 10 (4 KB page) gives `pa_o` = {desc[31:12], va[11:0]} and `size_o` = 2.
- R9: A second-level descriptor with bits [1:0] = 00 ends the walk with `fault_o`=1 and `fault_lvl_o`=1.
- R10: For any second-level page, `attr_o` = {desc[5:4], desc[3], desc[2]}, meaning access bits, then the C flag, then the B flag.
- R11: `done_o` is high for exactly one cycle per walk, in the cycle after the final response has been taken.
- R12: While `mem_req_o` is high and no response has arrived, `mem_req_o` stays high and `mem_addr_o` stays unchanged in the next cycle. Every read address is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request taken |
| req_va_i | input | 32 | Virtual address to translate |
| ttb_i | input | 32 | Translation-table base; bits [31:14] used |
| mem_req_o | output | 1 | Word read outstanding |
| mem_addr_o | output | 32 | Byte address of the word read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data (descriptor) |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Walk ended in a translation fault |
| fault_lvl_o | output | 1 | Faulting level: 0 first, 1 second |
| pa_o | output | 32 | Physical address |
| attr_o | output | 4 | {access[1:0], C, B} |
| size_o | output | 2 | 0 section, 1 large page, 2 small page |

## Verification
The assertions assume one rule about the memory side: `mem_rsp_valid_i` is raised only while `mem_req_o` is high, and only once for each read. They also assume that the translation-table base does not matter after a request has been taken. The bench's responder never answers an idle port, and it answers each read exactly once after a delay that cycles through zero to three cycles. One request is held high into the busy period with a different address, to show that it is ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ADDR_W    = 32;
  localparam int L1_IDX_W  = 12;
  localparam int TTB_W     = ADDR_W - L1_IDX_W - 2;
  localparam int ATTR_W    = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_L1, ST_L2, ST_DONE} walk_state_e;

  localparam logic [1:0] SZ_SECTION = 2'd0;
  localparam logic [1:0] SZ_LARGE   = 2'd1;
  localparam logic [1:0] SZ_SMALL   = 2'd2;

  typedef struct packed {
    logic              fault;
    logic [ADDR_W-1:0] pa;
    logic [ATTR_W-1:0] attr;
    logic [1:0]        size;
  } walk_res_t;
endpackage

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode
  import ptw_pkg::*;
(
  input  logic [ADDR_W-1:0] desc_i,
  input  logic [19:0]       va_lo_i,
  output logic              fault_o,
  output logic              final_o,
  output logic [ADDR_W-1:0] next_addr_o,
  output walk_res_t         res_o
);
  logic unused_bits;
  assign unused_bits = ^desc_i[9:4];

  always_comb begin
    fault_o     = 1'b0;
    final_o     = 1'b0;
    next_addr_o = '0;
    res_o       = '0;
    unique case (desc_i[1:0])
      2'b00: begin
        fault_o     = 1'b1;
        final_o     = 1'b1;
        res_o.fault = 1'b1;
      end
      2'b10: begin
        final_o    = 1'b1;
        res_o.pa   = {desc_i[31:20], va_lo_i};
        res_o.attr = {desc_i[11:10], desc_i[3], desc_i[2]};
        res_o.size = SZ_SECTION;
      end
      2'b01: next_addr_o = {desc_i[31:10], va_lo_i[19:12], 2'b00};
      default: next_addr_o = {desc_i[31:12], va_lo_i[19:10], 2'b00};
    endcase
  end
endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
  import ptw_pkg::*;
(
  input  logic [ADDR_W-1:0] desc_i,
  input  logic [15:0]       va_lo_i,
  output walk_res_t         res_o
);
  logic unused_bits;
  assign unused_bits = ^desc_i[11:6];

  always_comb begin
    res_o      = '0;
    res_o.attr = {desc_i[5:4], desc_i[3], desc_i[2]};
    unique case (desc_i[1:0])
      2'b00: begin
        res_o.fault = 1'b1;
        res_o.attr  = '0;
      end
      2'b01: begin
        res_o.pa   = {desc_i[31:16], va_lo_i};
        res_o.size = SZ_LARGE;
      end
      default: begin
        res_o.pa   = {desc_i[31:12], va_lo_i[11:0]};
        res_o.size = SZ_SMALL;
      end
    endcase
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_va_i,
  input  logic [ADDR_W-1:0] ttb_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [ADDR_W-1:0] mem_rsp_data_i,
  output logic              done_o,
  output logic              fault_o,
  output logic              fault_lvl_o,
  output logic [ADDR_W-1:0] pa_o,
  output logic [ATTR_W-1:0] attr_o,
  output logic [1:0]        size_o
);
  walk_state_e       st_q;
  logic [ADDR_W-1:0] va_q;
  logic [TTB_W-1:0]  ttb_q;
  logic [ADDR_W-1:0] l2_addr_q;
  walk_res_t         res_q;
  logic              lvl_q;

  logic              l1_fault, l1_final;
  logic [ADDR_W-1:0] l1_next;
  walk_res_t         l1_res, l2_res;
  logic              unused_ttb;

  assign unused_ttb = ^ttb_i[ADDR_W-TTB_W-1:0];

  ptw_l1_decode u_l1 (
    .desc_i      (mem_rsp_data_i),
    .va_lo_i     (va_q[19:0]),
    .fault_o     (l1_fault),
    .final_o     (l1_final),
    .next_addr_o (l1_next),
    .res_o       (l1_res)
  );

  ptw_l2_decode u_l2 (
    .desc_i  (mem_rsp_data_i),
    .va_lo_i (va_q[15:0]),
    .res_o   (l2_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      va_q      <= '0;
      ttb_q     <= '0;
      l2_addr_q <= '0;
      res_q     <= '0;
      lvl_q     <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          va_q  <= req_va_i;
          ttb_q <= ttb_i[ADDR_W-1:ADDR_W-TTB_W];
          st_q  <= ST_L1;
        end
        ST_L1: if (mem_rsp_valid_i) begin
          lvl_q <= 1'b0;
          if (l1_final) begin
            res_q <= l1_res;
            st_q  <= ST_DONE;
          end else begin
            l2_addr_q <= l1_next;
            st_q      <= ST_L2;
          end
        end
        ST_L2: if (mem_rsp_valid_i) begin
          res_q <= l2_res;
          lvl_q <= 1'b1;
          st_q  <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign mem_req_o   = (st_q == ST_L1) || (st_q == ST_L2);
  assign mem_addr_o  = (st_q == ST_L2) ? l2_addr_q
                                       : {ttb_q, va_q[ADDR_W-1:ADDR_W-L1_IDX_W], 2'b00};
  assign done_o      = (st_q == ST_DONE);
  assign fault_o     = res_q.fault;
  assign fault_lvl_o = lvl_q & res_q.fault;
  assign pa_o        = res_q.pa;
  assign attr_o      = res_q.attr;
  assign size_o      = res_q.size;

  // l1 fault never reaches the second level
  logic unused_l1f;
  assign unused_l1f = l1_fault;

  p_busy_no_ready_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_ready_o && (mem_req_o || done_o)));

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_rsp_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(mem_rsp_valid_i && mem_req_o));

  p_hold_addr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rsp_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_word_aligned_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  p_l1_fault_lvl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o && !fault_lvl_o) |-> $past(!mem_addr_o[0] && mem_rsp_data_i[1:0] == 2'b00));
endmodule

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [31:0] ttb = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        done, fault, fault_lvl;
  logic [31:0] pa;
  logic [3:0]  attr;
  logic [1:0]  size;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  ptw_walker dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_va_i(req_va), .ttb_i(ttb), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data), .done_o(done),
    .fault_o(fault), .fault_lvl_o(fault_lvl), .pa_o(pa), .attr_o(attr), .size_o(size)
  );

  typedef struct {
    logic        fault;
    logic        lvl;
    logic [31:0] pa;
    logic [3:0]  attr;
    logic [1:0]  size;
    int          nrd;
    logic [31:0] a0;
    logic [31:0] a1;
    string       tag;
  } exp_t;

  logic [31:0] mem [logic [31:0]];
  exp_t        sb_q[$];
  logic [31:0] rd_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic exp_t model(input logic [31:0] va, input logic [31:0] tb, input string tag);
    exp_t e;
    logic [31:0] d1, d2;
    e = '{fault:0, lvl:0, pa:0, attr:0, size:0, nrd:1, a0:0, a1:0, tag:tag};
    e.a0 = {tb[31:14], va[31:20], 2'b00};
    d1 = rd(e.a0);
    case (d1[1:0])
      2'b00: e.fault = 1'b1;
      2'b10: begin
        e.pa = {d1[31:20], va[19:0]}; e.attr = {d1[11:10], d1[3], d1[2]}; e.size = 2'd0;
      end
      default: begin
        e.nrd = 2;
        e.a1 = (d1[1:0] == 2'b01) ? {d1[31:10], va[19:12], 2'b00} : {d1[31:12], va[19:10], 2'b00};
        d2 = rd(e.a1);
        e.attr = {d2[5:4], d2[3], d2[2]};
        case (d2[1:0])
          2'b00: begin e.fault = 1'b1; e.lvl = 1'b1; end
          2'b01: begin e.pa = {d2[31:16], va[15:0]}; e.size = 2'd1; end
          default: begin e.pa = {d2[31:12], va[11:0]}; e.size = 2'd2; end
        endcase
      end
    endcase
    return e;
  endfunction

  // memory responder: delay cycles through 0..3
  initial begin
    int dly = 0;
    int seed = 1;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (mem_req) begin
        if (dly == 0) begin
          rsp_valid = 1'b1;
          rsp_data  = rd(mem_addr);
          rd_q.push_back(mem_addr);
          dly  = seed % 4;
          seed = seed + 1;
        end else dly--;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        if (sb_q.size() == 0) begin
          chk("R11 unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk({e.tag, " fault"}, {31'd0, fault}, {31'd0, e.fault});
          if (e.fault) chk({e.tag, " R3/R9 level"}, {31'd0, fault_lvl}, {31'd0, e.lvl});
          else begin
            chk({e.tag, " pa"}, pa, e.pa);
            chk({e.tag, " size"}, {30'd0, size}, {30'd0, e.size});
            chk({e.tag, " R10 attr"}, {28'd0, attr}, {28'd0, e.attr});
          end
          chk({e.tag, " R12 read count"}, rd_q.size(), e.nrd);
          if (rd_q.size() > 0) chk({e.tag, " R2 first read"}, rd_q[0], e.a0);
          if (rd_q.size() > 1 && e.nrd > 1) chk({e.tag, " R5/R6 second read"}, rd_q[1], e.a1);
          rd_q.delete();
          @(negedge clk);
          chk("R11 done one cycle", {31'd0, done}, 32'd0);
        end
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [31:0] tb, input string tag, input bit busy_poke);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    sb_q.push_back(model(va, tb, tag));
    req_valid = 1'b1; req_va = va; ttb = tb;
    @(negedge clk);
    chk("R1 ready low while busy", {31'd0, req_ready}, 32'd0);
    if (busy_poke) begin
      req_va = va ^ 32'hFFF0_0000;
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    bit timeout = 0;
    mem[32'h0004_048C] = 32'h8760_0C0E;
    mem[32'h0004_0800] = 32'h0008_0401;
    mem[32'h0008_04D0] = 32'hABCD_E03A;
    mem[32'h0008_0554] = 32'h1111_1017;
    mem[32'h0008_06AC] = 32'h5555_0005;
    mem[32'h0004_0C04] = 32'h0009_0003;
    mem[32'h0009_0234] = 32'hCAFE_F02E;
    mem[32'h00FF_FFFC] = 32'hFFF0_0002;
    repeat (3) @(negedge clk);
    chk("R1 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R11 reset done", {31'd0, done}, 32'd0);
    chk("R12 reset mem_req", {31'd0, mem_req}, 32'd0);
    rst_n = 1'b1;
    fork
      begin
        walk(32'h0010_0123, 32'h0004_0000, "R3 l1 fault", 0);
        walk(32'h1234_5678, 32'h0004_0000, "R4 section", 0);
        walk(32'h2003_4ABC, 32'h0004_0000, "R5 R8 coarse small new", 1);
        walk(32'h2005_5111, 32'h0004_0000, "R8 coarse small ext", 0);
        walk(32'h200A_BCDE, 32'h0004_0000, "R7 coarse large", 1);
        walk(32'h200F_F000, 32'h0004_0000, "R9 l2 fault", 0);
        walk(32'h3012_3456, 32'h0004_0000, "R6 fine small", 0);
        walk(32'hFFF0_0001, 32'h00FF_C000, "R2 top entry section", 1);
        walk(32'h1234_5678, 32'h0004_3FFF, "R2 ttb low bits ignored", 0);
        repeat (5) @(negedge clk);
      end
      begin
        repeat (20000) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    if (timeout) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule